// File: doc/BRIEF.md
# Memory Bus Cycle Sequencer

This block produces the processor-side strobe timing for external memory accesses. A client posts a request carrying a cycle kind, an address and write data. The block then plays out an opcode fetch, a memory read or a memory write on a bus made of an address, active-low strobes (memory request, read, write, first-machine-cycle marker and refresh marker) and a data byte split into in, out and output-enable. The memory can stretch any cycle by holding the wait input low. A one-cycle done pulse closes the cycle, and read data is presented with it.

The block runs from one clock at twice the T-state rate. Each T state has two half slots: the first half follows the rising edge of the T-state clock and the second half follows its falling edge. Every bus output is registered, so a strobe can start at either half of a T state. This lets each strobe act directly as a chip enable or as a write pulse. An opcode fetch finishes with two T states that put a refresh address on the bus. A 7-bit counter, advanced after every fetch, supplies that address.

Top module: `bus_cycle_seq`

## Requirements
- R1: With `wait_n` high, a read or write cycle (`req_kind` 1 = read, 2 = write) lasts three T states T1, T2, T3, which is six clocks. `done` is high only in the second half of T3, for exactly one clock.
- R2: `wait_n` is sampled only at the clock that starts the second half of T2 and of each wait state. A low sample inserts one wait state (two clocks) after T2 and before T3. `wait_n` has no effect at any other clock, and each inserted wait state delays `done` by two clocks.
- R3: In a read or write cycle, `mreq_n` is low from the second half of T1 to the end of T3. The request address is on `addr` from the first half of T1, so `addr` is already stable when `mreq_n` falls.
- R4: In a read, `rd_n` is low from the second half of T1 to the end of T3. `data_in` is captured at the clock that starts the second half of T3 and is shown on `rd_data` while `done` is high. `rd_n` and `wr_n` are never low together.
- R5: In a write, `data_oe` is high and `data_out` equals the request data through T1 to T3. `wr_n` is low from the second half of T2 to the end of the first half of T3. It therefore rises half a T state before the address and data can change.
- R6: An opcode fetch (`req_kind` 0) lasts four T states plus waits. `m1_n` is low during T1, T2 and any wait states, with the request address on `addr`. `mreq_n` and `rd_n` are low from the second half of T1 until T3 begins. `data_in` is captured at the clock that starts T3, and `done` is high in the second half of T4.
- R7: During T3 and T4 of a fetch, `rfsh_n` is low and `addr` = {low 8 bits of REFRESH_PAGE, 0, 7-bit count}. `mreq_n` is low in the second half of T3 and the first half of T4. The count starts at 0, rises by one after each fetch and wraps from 127 to 0, and bit 7 of the address stays 0.
- R8: During and after reset, with no request, all strobes are high, `data_oe` and `done` are low, `req_ready` is high and `addr` is 0.
- R9: `req_ready` is high only when idle or in the final half slot of a cycle. A request presented while `req_ready` is low is ignored. A request accepted in the final half slot starts T1 on the very next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock, two per T state |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write |
| req_addr | input | 16 | Address for the cycle |
| req_wdata | input | 8 | Data for a write |
| req_ready | output | 1 | Request will be taken this clock |
| done | output | 1 | One-clock end-of-cycle pulse |
| rd_data | output | 8 | Byte captured by a fetch or read |
| addr | output | 16 | Address bus |
| data_out | output | 8 | Data bus out |
| data_oe | output | 1 | Data bus output enable |
| data_in | input | 8 | Data bus in |
| mreq_n | output | 1 | Memory request strobe |
| rd_n | output | 1 | Read strobe |
| wr_n | output | 1 | Write strobe |
| m1_n | output | 1 | Opcode-fetch marker |
| rfsh_n | output | 1 | Refresh marker |
| wait_n | input | 1 | Wait request from memory |

## Verification
All outputs come from registers, so each bus signal settles one clock after the edge that enters its half slot. An accepted request shows T1's first half one clock later. A cycle of k half slots raises `done` k clocks after acceptance, which is 6 or 8 clocks plus two per wait state. The bench checks every output in every half slot at the falling clock edge, after that slot's registers have loaded. It changes `data_in` so that the correct byte is present only across the single capture edge. It drives `wait_n` low in every slot where the block must ignore it.

// File: rtl/seq_pkg.sv
package seq_pkg;
    typedef enum logic [1:0] {
        K_FETCH = 2'd0,
        K_READ  = 2'd1,
        K_WRITE = 2'd2,
        K_SPARE = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        TS_IDLE = 3'd0,
        TS_T1   = 3'd1,
        TS_T2   = 3'd2,
        TS_TW   = 3'd3,
        TS_T3   = 3'd4,
        TS_T4   = 3'd5
    } tstate_e;

    typedef struct packed {
        tstate_e ts;
        logic    half;
        kind_e   kind;
    } slot_t;

    localparam slot_t SLOT_IDLE = '{ts: TS_IDLE, half: 1'b0, kind: K_READ};

    // Last half slot of a cycle: T3 second half for data cycles, T4 second half for fetches.
    function automatic logic slot_final(slot_t s);
        return s.half && ((s.ts == TS_T4) || (s.ts == TS_T3 && s.kind != K_FETCH));
    endfunction
endpackage

// File: rtl/seq_timing.sv
module seq_timing
    import seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_kind,
    input  logic       wait_n,
    output slot_t      slot_d_o,
    output logic       was_t3,
    output logic       req_ready,
    output logic       accept,
    output logic       fetch_end
);
    typedef struct packed {
        slot_t slot;
        logic  wait_hit;
    } tim_t;

    tim_t q, d;

    always_comb begin
        d         = q;
        req_ready = (q.slot.ts == TS_IDLE) || slot_final(q.slot);
        accept    = req_valid && req_ready;
        fetch_end = (q.slot.ts == TS_T4) && q.slot.half;
        was_t3    = (q.slot.ts == TS_T3);

        if (accept) begin
            d.slot.ts   = TS_T1;
            d.slot.half = 1'b0;
            d.slot.kind = kind_e'(req_kind);
        end else if (q.slot.ts == TS_IDLE) begin
            d.slot = q.slot;
        end else if (!q.slot.half) begin
            // Mid-T-state edge: the only place the wait input is looked at.
            d.slot.half = 1'b1;
            if (q.slot.ts == TS_T2 || q.slot.ts == TS_TW) begin
                d.wait_hit = !wait_n;
            end
        end else begin
            d.slot.half = 1'b0;
            case (q.slot.ts)
                TS_T1:        d.slot.ts = TS_T2;
                TS_T2, TS_TW: d.slot.ts = q.wait_hit ? TS_TW : TS_T3;
                TS_T3:        d.slot.ts = (q.slot.kind == K_FETCH) ? TS_T4 : TS_IDLE;
                default:      d.slot.ts = TS_IDLE;
            endcase
        end
        slot_d_o = d.slot;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{slot: SLOT_IDLE, wait_hit: 1'b0};
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/seq_refresh.sv
module seq_refresh #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = bump ? cnt_q + 1'b1 : cnt_q;
        count = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/seq_bus_drive.sv
module seq_bus_drive
    import seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 7,
    parameter logic [ADDR_W-1:0] REFRESH_PAGE = 16'h00A5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  slot_t             slot_d,
    input  logic              was_t3,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [CNT_W-1:0]  rcount,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              mreq_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              m1_n,
    output logic              rfsh_n
);
    localparam int PAGE_W = ADDR_W - CNT_W - 1;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] cur;
        logic [DATA_W-1:0] dout;
        logic [DATA_W-1:0] rdata;
        logic              oe;
        logic              done;
        logic              mreq_n;
        logic              rd_n;
        logic              wr_n;
        logic              m1_n;
        logic              rfsh_n;
    } drv_t;

    drv_t q, d;
    logic is_f, is_w, is_r, busy, h, early, mid, t3, t4;
    logic [ADDR_W-1:0] refresh_addr;

    always_comb begin
        d     = q;
        is_f  = (slot_d.kind == K_FETCH);
        is_w  = (slot_d.kind == K_WRITE);
        is_r  = !is_f && !is_w;
        busy  = (slot_d.ts != TS_IDLE);
        h     = slot_d.half;
        early = (slot_d.ts == TS_T1) && h;
        mid   = (slot_d.ts == TS_T2) || (slot_d.ts == TS_TW);
        t3    = (slot_d.ts == TS_T3);
        t4    = (slot_d.ts == TS_T4);
        refresh_addr = {REFRESH_PAGE[PAGE_W-1:0], 1'b0, rcount};

        if (accept) begin
            d.cur  = req_addr;
            d.dout = req_wdata;
        end
        if (busy) begin
            d.addr = (is_f && (t3 || t4)) ? refresh_addr : d.cur;
        end

        d.mreq_n = !(busy && (is_f ? (early || mid || (t3 && h) || (t4 && !h))
                                   : (early || mid || t3)));
        d.rd_n   = !(busy && !is_w && (early || mid || (is_r && t3)));
        d.wr_n   = !(busy && is_w && (((slot_d.ts == TS_T2) && h) ||
                                      (slot_d.ts == TS_TW) || (t3 && !h)));
        d.m1_n   = !(busy && is_f && ((slot_d.ts == TS_T1) || mid));
        d.rfsh_n = !(busy && is_f && (t3 || t4));
        d.oe     = busy && is_w && !t4;
        d.done   = busy && slot_final(slot_d);

        // Fetch data is taken as T3 opens; read data in the middle of T3.
        if (is_f && t3 && !h && !was_t3) begin
            d.rdata = data_in;
        end
        if (is_r && t3 && h) begin
            d.rdata = data_in;
        end

        addr     = q.addr;
        data_out = q.dout;
        data_oe  = q.oe;
        rd_data  = q.rdata;
        done     = q.done;
        mreq_n   = q.mreq_n;
        rd_n     = q.rd_n;
        wr_n     = q.wr_n;
        m1_n     = q.m1_n;
        rfsh_n   = q.rfsh_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{addr: '0, cur: '0, dout: '0, rdata: '0, oe: 1'b0, done: 1'b0,
                   mreq_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1, m1_n: 1'b1, rfsh_n: 1'b1};
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 7,
    parameter logic [ADDR_W-1:0] REFRESH_PAGE = 16'h00A5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    input  logic [DATA_W-1:0] data_in,
    output logic              mreq_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              m1_n,
    output logic              rfsh_n,
    input  logic              wait_n
);
    slot_t            slot_d;
    logic             was_t3, accept, fetch_end;
    logic [CNT_W-1:0] rcount;

    seq_timing u_timing (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .wait_n    (wait_n),
        .slot_d_o  (slot_d),
        .was_t3    (was_t3),
        .req_ready (req_ready),
        .accept    (accept),
        .fetch_end (fetch_end)
    );

    seq_refresh #(.CNT_W(CNT_W)) u_refresh (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (fetch_end),
        .count (rcount)
    );

    seq_bus_drive #(
        .ADDR_W       (ADDR_W),
        .DATA_W       (DATA_W),
        .CNT_W        (CNT_W),
        .REFRESH_PAGE (REFRESH_PAGE)
    ) u_drive (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_d    (slot_d),
        .was_t3    (was_t3),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rcount    (rcount),
        .data_in   (data_in),
        .addr      (addr),
        .data_out  (data_out),
        .data_oe   (data_oe),
        .rd_data   (rd_data),
        .done      (done),
        .mreq_n    (mreq_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .m1_n      (m1_n),
        .rfsh_n    (rfsh_n)
    );
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              data_oe,
    input logic              done,
    input logic              req_ready,
    input logic              mreq_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic              m1_n,
    input logic              rfsh_n
);
    p_done_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_mreq_fall_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mreq_n) |-> $stable(addr));

    p_rd_wr_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n || wr_n);

    p_wr_needs_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> data_oe);

    p_wr_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> ($stable(addr) && data_oe));

    p_addr_hold_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && $past(!wr_n)) |-> $stable(addr));

    p_m1_rfsh_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        m1_n || rfsh_n);

    p_rfsh_after_m1_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rfsh_n) |-> $past(!m1_n));

    p_done_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);
endmodule

bind bus_cycle_seq seq_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .data_oe   (data_oe),
    .done      (done),
    .req_ready (req_ready),
    .mreq_n    (mreq_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .m1_n      (m1_n),
    .rfsh_n    (rfsh_n)
);

// File: tb/sim_bus_cycle_seq.sv
module sim_bus_cycle_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd1;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, done, data_oe;
    logic [7:0]  rd_data, data_out;
    logic [7:0]  data_in = '0;
    logic [15:0] addr;
    logic        mreq_n, rd_n, wr_n, m1_n, rfsh_n;
    logic        wait_n = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    int wd = 0;
    logic [6:0] rcnt = '0;

    always #2 clk = ~clk;

    bus_cycle_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .done(done), .rd_data(rd_data), .addr(addr), .data_out(data_out),
        .data_oe(data_oe), .data_in(data_in), .mreq_n(mreq_n), .rd_n(rd_n),
        .wr_n(wr_n), .m1_n(m1_n), .rfsh_n(rfsh_n), .wait_n(wait_n)
    );

    typedef struct packed {
        logic [1:0]  kind;
        logic [15:0] addr;
        logic [7:0]  wdata;
        logic [7:0]  rdata;
        logic [2:0]  nwait;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{2'd1, 16'h1234, 8'h00, 8'h5A, 3'd0},
        '{2'd2, 16'h8001, 8'hC3, 8'h00, 3'd0},
        '{2'd0, 16'h0100, 8'h00, 8'h3E, 3'd0},
        '{2'd1, 16'hFFFF, 8'h00, 8'hA5, 3'd2},
        '{2'd2, 16'h4000, 8'h7E, 8'h00, 3'd1},
        '{2'd0, 16'h0200, 8'h00, 8'h01, 3'd3},
        '{2'd1, 16'h0000, 8'h00, 8'hFF, 3'd1},
        '{2'd2, 16'hFFFE, 8'h00, 8'h00, 3'd2}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic check_idle(input string tag);
        logic [7:0] act;
        act = {mreq_n, rd_n, wr_n, m1_n, rfsh_n, data_oe, done, req_ready};
        chk(act == 8'b11111001, tag, {24'd0, act}, 32'h000000F9);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
            check_idle("R8 idle");
        end
    endtask

    // Slot codes: 1 T1, 2 T2, 3 Tw, 4 T3, 5 T4. Called and returns at a falling edge.
    task automatic do_cycle(input logic [1:0] kind, input logic [15:0] a, input logic [7:0] wd_v,
                            input logic [7:0] rdv, input int nwait, input bit poke);
        int  nslot, ts, widx, r;
        bit  h, f, w, rr, fin;
        bit  e_mreq, e_rd, e_wr, e_m1, e_rfsh;
        logic [15:0] e_addr;
        string tdone;
        f = (kind == 2'd0); w = (kind == 2'd2); rr = (kind == 2'd1);
        chk(req_ready == 1'b1, "R9 ready before request", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_kind = kind; req_addr = a; req_wdata = wd_v;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0; req_kind = 2'd3; req_addr = ~a; req_wdata = ~wd_v;
        nslot = (f ? 8 : 6) + 2 * nwait;
        tdone = f ? "R6 done" : (nwait > 0 ? "R2 done" : "R1 done");
        for (int s = 0; s < nslot; s++) begin
            widx = 0;
            h = s[0];
            if (s < 4) ts = (s < 2) ? 1 : 2;
            else if (s < 4 + 2 * nwait) begin ts = 3; widx = (s - 4) / 2; end
            else begin r = s - 4 - 2 * nwait; ts = (r < 2) ? 4 : 5; end
            fin = (s == nslot - 1);
            e_mreq = f ? ((ts == 1 && h) || ts == 2 || ts == 3 || (ts == 4 && h) || (ts == 5 && !h))
                       : !(ts == 1 && !h);
            e_rd   = f ? ((ts == 1 && h) || ts == 2 || ts == 3) : (rr && !(ts == 1 && !h));
            e_wr   = w && ((ts == 2 && h) || ts == 3 || (ts == 4 && !h));
            e_m1   = f && ts <= 3;
            e_rfsh = f && ts >= 4;
            e_addr = (f && ts >= 4) ? {8'hA5, 1'b0, rcnt} : a;
            chk(mreq_n == !e_mreq, f ? "R7 mreq_n fetch" : "R3 mreq_n", {31'd0, mreq_n}, {31'd0, !e_mreq});
            chk(rd_n == !e_rd, f ? "R6 rd_n" : "R4 rd_n", {31'd0, rd_n}, {31'd0, !e_rd});
            chk({wr_n, data_oe} == {!e_wr, w}, "R5 wr_n/data_oe", {30'd0, wr_n, data_oe}, {30'd0, !e_wr, w});
            chk(m1_n == !e_m1, "R6 m1_n", {31'd0, m1_n}, {31'd0, !e_m1});
            chk(rfsh_n == !e_rfsh, "R7 rfsh_n", {31'd0, rfsh_n}, {31'd0, !e_rfsh});
            chk(addr == e_addr, (f && ts >= 4) ? "R7 refresh addr" : "R3 addr", {16'd0, addr}, {16'd0, e_addr});
            chk(done == fin, tdone, {31'd0, done}, {31'd0, fin});
            chk(req_ready == fin, "R9 ready", {31'd0, req_ready}, {31'd0, fin});
            if (w) chk(data_out == wd_v, "R5 data_out", {24'd0, data_out}, {24'd0, wd_v});
            if (fin && !w) chk(rd_data == rdv, f ? "R6 fetch data" : "R4 read data", {24'd0, rd_data}, {24'd0, rdv});
            // Drive for the next edge; wait_n low where it must be ignored.
            if (ts == 2 && !h) wait_n = !(nwait > 0);
            else if (ts == 3 && !h) wait_n = !(widx + 1 < nwait);
            else wait_n = 1'b0;
            if (f) data_in = (s == 3 + 2 * nwait) ? rdv : ~rdv;
            else data_in = (ts == 4 && !h) ? rdv : ~rdv;
            if (poke && s == 2) begin req_valid = 1'b1; req_kind = 2'd2; end
            if (poke && s == 3) req_valid = 1'b0;
            if (!fin) begin @(posedge clk); @(negedge clk); end
        end
        if (f) rcnt = rcnt + 1'b1;
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below 100000", wd);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_idle("R8 reset strobes");
        chk(addr == 16'h0000, "R8 reset addr", {16'd0, addr}, 32'd0);
        rst_n = 1'b1;
        idle(2);

        for (int i = 0; i < NVEC; i++) begin
            do_cycle(VECS[i].kind, VECS[i].addr, VECS[i].wdata, VECS[i].rdata, int'(VECS[i].nwait), 1'b0);
            idle(1);
        end

        // R9: back-to-back requests taken in the final half slot.
        do_cycle(2'd0, 16'h1111, 8'h00, 8'h99, 0, 1'b0);
        do_cycle(2'd2, 16'h2222, 8'h5C, 8'h00, 0, 1'b0);
        do_cycle(2'd1, 16'h3333, 8'h00, 8'h66, 1, 1'b0);
        idle(1);

        // R9: request during a busy cycle is ignored.
        do_cycle(2'd1, 16'h0F0F, 8'h00, 8'h12, 0, 1'b1);
        do_cycle(2'd0, 16'h7777, 8'h00, 8'h34, 1, 1'b1);
        idle(2);

        // R7: refresh counter wraps through 127 back to 0.
        for (int i = 0; i < 130; i++) begin
            do_cycle(2'd0, 16'(i), 8'h00, 8'(i * 3), 0, 1'b0);
        end
        idle(2);

        summary();
        $finish;
    end
endmodule